// File: doc/BRIEF.md
# Operand Select, ALU and Branch Unit

This is the combinational execute stage of a small 8-bit processor. It takes one four-byte instruction (an opcode byte, two argument bytes and a destination byte, in that order) and the two values read from the register file. It produces either an arithmetic or logic result with a write request toward a destination register, or a branch decision with a jump target.

Each argument byte is used in one of two ways. It can address a register port, and the value read from that register becomes the operand. Or it can be taken as a literal, chosen by one of two flag bits in the opcode. With the flags removed, the low six opcode bits select the operation. One range of codes covers the arithmetic and logic operations. A second range covers the compare-and-branch operations, which take their jump target from the destination byte. The register file, memory, stack and fetch logic sit outside this block. The block has no clock and no state.

Top module: `aluops_top`

## Requirements
- R1: Opcode bit 7 set makes the first operand equal to the first argument byte. When it is clear, the first operand is `rd_val_a`. `rd_sel_a` always carries the low 3 bits of the first argument byte.
- R2: Opcode bit 6 set makes the second operand equal to the second argument byte. When it is clear, the second operand is `rd_val_b`. `rd_sel_b` always carries the low 3 bits of the second argument byte.
- R3: Code 0 adds the operands and code 1 subtracts the second from the first. Both results wrap modulo 256.
- R4: Code 2 gives the bitwise AND of the operands, code 3 the bitwise OR and code 5 the bitwise XOR.
- R5: Code 4 returns the bitwise inverse of the first operand. The second operand has no effect on the result.
- R6: Code 6 shifts the first operand right and code 7 shifts it left, in both cases by the value of the second operand. A count of 8 or more gives zero.
- R7: Code 10 gives the low 8 bits of the product of the operands.
- R8: For every arithmetic or logic code (0 to 7 and 10), `wb_en` is 1, `wb_sel` equals the low 3 bits of the destination byte and `br_take` is 0. Whenever `wb_en` is 0, `alu_res` is 0.
- R9: Codes 32 to 37 compare the operands as unsigned numbers, testing in turn for equal, not equal, less than, less or equal, greater than and greater or equal. When the test holds, `br_take` is 1 and `br_target` equals the destination byte. A branch code never raises `wb_en`.
- R10: Any other code (8, 9, 11 to 31, 38 to 63) sets `wb_en` to 0, `br_take` to 0 and `alu_res` to 0.
- R11: Opcode bits 7 and 6 change only where the operands come from. The operation is selected by bits 5 to 0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_op | input | 8 | Opcode byte: bit 7 selects a literal first operand, bit 6 a literal second operand, bits 5..0 select the operation |
| instr_arg1 | input | 8 | First argument byte: a literal or a register address |
| instr_arg2 | input | 8 | Second argument byte: a literal or a register address |
| instr_dst | input | 8 | Destination byte: a register address or a branch target |
| rd_sel_a | output | 3 | Register address for read port A |
| rd_sel_b | output | 3 | Register address for read port B |
| rd_val_a | input | 8 | Value read on port A |
| rd_val_b | input | 8 | Value read on port B |
| alu_res | output | 8 | Arithmetic or logic result |
| wb_en | output | 1 | Write request toward the destination register |
| wb_sel | output | 3 | Destination register address |
| br_take | output | 1 | Branch condition holds |
| br_target | output | 8 | Jump target |

## Verification
Random instruction words are drawn over the full opcode byte, so every combination of the two literal flags is paired with arithmetic, branch and undefined codes. This tells apart an error in operand sourcing from an error in the operation itself. The register model behind the read ports holds values that differ from the literal bytes, so a wrongly taken operand changes the result. Directed cases then cover the edges that random values seldom reach: subtraction below zero, products above 255, shift counts of exactly 7, 8 and 255, unsigned comparisons where the top bit is set, a NOT whose second operand is changed, and the undefined codes next to the valid ranges.

// File: rtl/aluops_pkg.sv
package aluops_pkg;

    localparam int OP_CODE_W = 6;
    localparam int OPF_IMM_A = 7;
    localparam int OPF_IMM_B = 6;

    localparam logic [OP_CODE_W-1:0] OPC_ADD = 6'd0;
    localparam logic [OP_CODE_W-1:0] OPC_SUB = 6'd1;
    localparam logic [OP_CODE_W-1:0] OPC_AND = 6'd2;
    localparam logic [OP_CODE_W-1:0] OPC_OR  = 6'd3;
    localparam logic [OP_CODE_W-1:0] OPC_NOT = 6'd4;
    localparam logic [OP_CODE_W-1:0] OPC_XOR = 6'd5;
    localparam logic [OP_CODE_W-1:0] OPC_SHR = 6'd6;
    localparam logic [OP_CODE_W-1:0] OPC_SHL = 6'd7;
    localparam logic [OP_CODE_W-1:0] OPC_MUL = 6'd10;

    localparam logic [OP_CODE_W-1:0] OPC_BEQ = 6'd32;
    localparam logic [OP_CODE_W-1:0] OPC_BNE = 6'd33;
    localparam logic [OP_CODE_W-1:0] OPC_BLT = 6'd34;
    localparam logic [OP_CODE_W-1:0] OPC_BLE = 6'd35;
    localparam logic [OP_CODE_W-1:0] OPC_BGT = 6'd36;
    localparam logic [OP_CODE_W-1:0] OPC_BGE = 6'd37;

endpackage

// File: rtl/aluops_opsel.sv
module aluops_opsel #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          use_lit,
    input  logic [W-1:0]  arg_byte,
    input  logic [W-1:0]  reg_val,
    output logic [AW-1:0] reg_sel,
    output logic [W-1:0]  operand
);

    always_comb begin
        reg_sel = arg_byte[AW-1:0];
        operand = use_lit ? arg_byte : reg_val;
    end

endmodule

// File: rtl/aluops_alu.sv
module aluops_alu
    import aluops_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_CODE_W-1:0] code,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic [W-1:0]         res,
    output logic                 hit
);

    localparam int           SHW    = $clog2(W);
    localparam logic [W-1:0] SH_MAX = W'(W - 1);

    logic          sh_over;
    logic [SHW-1:0] sh_amt;

    always_comb begin
        sh_over = (b > SH_MAX);
        sh_amt  = b[SHW-1:0];
        hit     = 1'b1;
        res     = '0;
        case (code)
            OPC_ADD: res = a + b;
            OPC_SUB: res = a - b;
            OPC_AND: res = a & b;
            OPC_OR:  res = a | b;
            OPC_NOT: res = ~a;
            OPC_XOR: res = a ^ b;
            OPC_SHR: res = sh_over ? '0 : (a >> sh_amt);
            OPC_SHL: res = sh_over ? '0 : (a << sh_amt);
            OPC_MUL: res = a * b;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/aluops_branch.sv
module aluops_branch
    import aluops_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_CODE_W-1:0] code,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic                 hit,
    output logic                 cond
);

    logic eq_v;
    logic lt_v;

    always_comb begin
        eq_v = (a == b);
        lt_v = (a < b);
        hit  = 1'b1;
        cond = 1'b0;
        case (code)
            OPC_BEQ: cond = eq_v;
            OPC_BNE: cond = !eq_v;
            OPC_BLT: cond = lt_v;
            OPC_BLE: cond = lt_v || eq_v;
            OPC_BGT: cond = !(lt_v || eq_v);
            OPC_BGE: cond = !lt_v;
            default: hit  = 1'b0;
        endcase
    end

endmodule

// File: rtl/aluops_top.sv
module aluops_top
    import aluops_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic [7:0]    instr_op,
    input  logic [W-1:0]  instr_arg1,
    input  logic [W-1:0]  instr_arg2,
    input  logic [W-1:0]  instr_dst,
    output logic [AW-1:0] rd_sel_a,
    output logic [AW-1:0] rd_sel_b,
    input  logic [W-1:0]  rd_val_a,
    input  logic [W-1:0]  rd_val_b,
    output logic [W-1:0]  alu_res,
    output logic          wb_en,
    output logic [AW-1:0] wb_sel,
    output logic          br_take,
    output logic [W-1:0]  br_target
);

    localparam int NSRC = 2;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wen;
        logic         take;
    } exec_t;

    logic [OP_CODE_W-1:0] code;
    logic [NSRC-1:0]      lit_flag;
    logic [W-1:0]         arg_v [NSRC];
    logic [W-1:0]         rval_v[NSRC];
    logic [AW-1:0]        sel_v [NSRC];
    logic [W-1:0]         opnd_v[NSRC];

    logic [W-1:0] alu_raw;
    logic         alu_hit;
    logic         br_hit;
    logic         br_cond;
    exec_t        exec_d;

    assign code      = instr_op[OP_CODE_W-1:0];
    assign lit_flag  = {instr_op[OPF_IMM_B], instr_op[OPF_IMM_A]};
    assign arg_v[0]  = instr_arg1;
    assign arg_v[1]  = instr_arg2;
    assign rval_v[0] = rd_val_a;
    assign rval_v[1] = rd_val_b;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            aluops_opsel #(.W(W), .AW(AW)) u_opsel (
                .use_lit  (lit_flag[i]),
                .arg_byte (arg_v[i]),
                .reg_val  (rval_v[i]),
                .reg_sel  (sel_v[i]),
                .operand  (opnd_v[i])
            );
        end
    endgenerate

    aluops_alu #(.W(W)) u_alu (
        .code (code),
        .a    (opnd_v[0]),
        .b    (opnd_v[1]),
        .res  (alu_raw),
        .hit  (alu_hit)
    );

    aluops_branch #(.W(W)) u_branch (
        .code (code),
        .a    (opnd_v[0]),
        .b    (opnd_v[1]),
        .hit  (br_hit),
        .cond (br_cond)
    );

    always_comb begin
        exec_d      = '0;
        exec_d.wen  = alu_hit;
        exec_d.res  = alu_hit ? alu_raw : '0;
        exec_d.take = br_hit && br_cond;
    end

    assign rd_sel_a  = sel_v[0];
    assign rd_sel_b  = sel_v[1];
    assign alu_res   = exec_d.res;
    assign wb_en     = exec_d.wen;
    assign wb_sel    = instr_dst[AW-1:0];
    assign br_take   = exec_d.take;
    assign br_target = instr_dst;

endmodule

// File: rtl/aluops_chk.sv
module aluops_chk #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input logic [7:0]    instr_op,
    input logic [W-1:0]  instr_arg1,
    input logic [W-1:0]  instr_arg2,
    input logic [W-1:0]  instr_dst,
    input logic [AW-1:0] rd_sel_a,
    input logic [AW-1:0] rd_sel_b,
    input logic [W-1:0]  rd_val_a,
    input logic [W-1:0]  rd_val_b,
    input logic [W-1:0]  alu_res,
    input logic          wb_en,
    input logic [AW-1:0] wb_sel,
    input logic          br_take,
    input logic [W-1:0]  br_target
);

    logic [5:0]   c_code;
    logic [W-1:0] c_opa;
    logic         c_undef;

    always_comb begin
        c_code  = instr_op[5:0];
        c_opa   = instr_op[7] ? instr_arg1 : rd_val_a;
        c_undef = !((c_code <= 6'd7) || (c_code == 6'd10) ||
                    ((c_code >= 6'd32) && (c_code <= 6'd37)));

        assert_sel_a_R1: assert (rd_sel_a == instr_arg1[AW-1:0])
            else $error("rd_sel_a does not follow arg1");
        assert_sel_b_R2: assert (rd_sel_b == instr_arg2[AW-1:0])
            else $error("rd_sel_b does not follow arg2");
        if (c_code == 6'd4) begin
            assert_not_R5: assert (alu_res == ~c_opa)
                else $error("NOT result wrong");
        end
        if (wb_en) begin
            assert_wsel_R8: assert (wb_sel == instr_dst[AW-1:0])
                else $error("wb_sel differs from destination");
        end else begin
            assert_idle_res_R8: assert (alu_res == '0)
                else $error("result nonzero without write");
        end
        assert_excl_R9: assert (!(wb_en && br_take))
            else $error("write and branch together");
        if (br_take) begin
            assert_target_R9: assert (br_target == instr_dst)
                else $error("branch target wrong");
        end
        if (c_undef) begin
            assert_undef_R10: assert (!wb_en && !br_take)
                else $error("undefined code acted");
        end
    end

endmodule

bind aluops_top aluops_chk #(.W(W), .AW(AW)) u_chk (
    .instr_op   (instr_op),
    .instr_arg1 (instr_arg1),
    .instr_arg2 (instr_arg2),
    .instr_dst  (instr_dst),
    .rd_sel_a   (rd_sel_a),
    .rd_sel_b   (rd_sel_b),
    .rd_val_a   (rd_val_a),
    .rd_val_b   (rd_val_b),
    .alu_res    (alu_res),
    .wb_en      (wb_en),
    .wb_sel     (wb_sel),
    .br_take    (br_take),
    .br_target  (br_target)
);

// File: tb/aluops_top_tb.sv
module aluops_top_tb;

    logic       clk;
    logic       rst;
    logic [7:0] instr_op, instr_arg1, instr_arg2, instr_dst;
    logic [2:0] rd_sel_a, rd_sel_b, wb_sel;
    logic [7:0] rd_val_a, rd_val_b, alu_res, br_target;
    logic       wb_en, br_take;
    logic [7:0] regs [8];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    aluops_top u_dut (
        .instr_op   (instr_op),
        .instr_arg1 (instr_arg1),
        .instr_arg2 (instr_arg2),
        .instr_dst  (instr_dst),
        .rd_sel_a   (rd_sel_a),
        .rd_sel_b   (rd_sel_b),
        .rd_val_a   (rd_val_a),
        .rd_val_b   (rd_val_b),
        .alu_res    (alu_res),
        .wb_en      (wb_en),
        .wb_sel     (wb_sel),
        .br_take    (br_take),
        .br_target  (br_target)
    );

    assign rd_val_a = regs[rd_sel_a];
    assign rd_val_b = regs[rd_sel_b];

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic string tag_of(input logic [5:0] c);
        if (c <= 6'd1) return "R3";
        if (c == 6'd2 || c == 6'd3 || c == 6'd5) return "R4";
        if (c == 6'd4) return "R5";
        if (c == 6'd6 || c == 6'd7) return "R6";
        if (c == 6'd10) return "R7";
        if (c >= 6'd32 && c <= 6'd37) return "R9";
        return "R10";
    endfunction

    function automatic void model(input logic [7:0] op, a1, a2, dst,
                                  output logic [7:0] res, output logic wen,
                                  output logic [2:0] wsel, output logic take,
                                  output logic [7:0] tgt);
        logic [7:0]  a, b;
        logic [5:0]  c;
        logic [15:0] prod;
        a    = op[7] ? a1 : regs[a1[2:0]];
        b    = op[6] ? a2 : regs[a2[2:0]];
        c    = op[5:0];
        res  = 8'd0;
        wen  = 1'b1;
        take = 1'b0;
        wsel = dst[2:0];
        tgt  = dst;
        prod = 16'(a) * 16'(b);
        case (c)
            6'd0:  res = 8'((9'(a) + 9'(b)) % 256);
            6'd1:  res = 8'((9'd256 + 9'(a) - 9'(b)) % 256);
            6'd2:  res = a & b;
            6'd3:  res = a | b;
            6'd4:  res = ~a;
            6'd5:  res = a ^ b;
            6'd6:  res = (b >= 8) ? 8'd0 : 8'(a >> b);
            6'd7:  res = (b >= 8) ? 8'd0 : 8'(a << b);
            6'd10: res = prod[7:0];
            6'd32: begin wen = 1'b0; take = (a == b); end
            6'd33: begin wen = 1'b0; take = (a != b); end
            6'd34: begin wen = 1'b0; take = (a <  b); end
            6'd35: begin wen = 1'b0; take = (a <= b); end
            6'd36: begin wen = 1'b0; take = (a >  b); end
            6'd37: begin wen = 1'b0; take = (a >= b); end
            default: wen = 1'b0;
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] op, a1, a2, dst, input string req);
        logic [7:0] e_res, e_tgt;
        logic       e_wen, e_take;
        logic [2:0] e_wsel;
        @(negedge clk);
        instr_op = op; instr_arg1 = a1; instr_arg2 = a2; instr_dst = dst;
        #1;
        model(op, a1, a2, dst, e_res, e_wen, e_wsel, e_take, e_tgt);
        cmp(req, "alu_res", int'(alu_res), int'(e_res));
        cmp(req, "wb_en", int'(wb_en), int'(e_wen));
        cmp(req, "br_take", int'(br_take), int'(e_take));
        if (e_wen) cmp(req, "wb_sel", int'(wb_sel), int'(e_wsel));
        if (e_take) cmp(req, "br_target", int'(br_target), int'(e_tgt));
        cmp(req, "rd_sel_a R1", int'(rd_sel_a), int'(a1[2:0]));
        cmp(req, "rd_sel_b R2", int'(rd_sel_b), int'(a2[2:0]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5151));
        for (int i = 0; i < 8; i++) regs[i] = 8'(8'd17 * i + 8'd3);
        regs[3] = 8'd200; regs[4] = 8'd5;
        rst = 1'b1;
        instr_op = '0; instr_arg1 = '0; instr_arg2 = '0; instr_dst = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero instruction is add r0+r0 to r0 (R8)
        run(8'h00, 8'h00, 8'h00, 8'h00, "R8");
        // literal vs register operands (R1, R2, R11)
        run(8'h00, 8'd3, 8'd4, 8'd2, "R1");
        run(8'h80, 8'd3, 8'd4, 8'd2, "R1");
        run(8'h40, 8'd3, 8'd4, 8'd2, "R2");
        run(8'hC0, 8'd3, 8'd4, 8'd2, "R11");
        // add/sub wrap (R3)
        run(8'hC0, 8'd200, 8'd100, 8'd1, "R3");
        run(8'hC1, 8'd5, 8'd10, 8'd1, "R3");
        // logic ops (R4)
        run(8'hC2, 8'hF0, 8'h3C, 8'd6, "R4");
        run(8'hC3, 8'hF0, 8'h3C, 8'd6, "R4");
        run(8'hC5, 8'hF0, 8'h3C, 8'd6, "R4");
        // NOT ignores second operand (R5)
        run(8'hC4, 8'h5A, 8'h00, 8'd1, "R5");
        run(8'hC4, 8'h5A, 8'hFF, 8'd1, "R5");
        run(8'h84, 8'h5A, 8'd3, 8'd1, "R5");
        // shifts incl. count limits (R6)
        run(8'hC6, 8'h80, 8'd7, 8'd0, "R6");
        run(8'hC7, 8'h01, 8'd7, 8'd0, "R6");
        run(8'hC7, 8'hFF, 8'd8, 8'd0, "R6");
        run(8'hC6, 8'hFF, 8'd255, 8'd0, "R6");
        // multiply low byte (R7)
        run(8'hCA, 8'd20, 8'd20, 8'd2, "R7");
        run(8'hCA, 8'd255, 8'd255, 8'd2, "R7");
        // destination select (R8)
        run(8'hC0, 8'd1, 8'd1, 8'hFD, "R8");
        // branches, unsigned (R9)
        run(8'hE0, 8'd9, 8'd9, 8'h44, "R9");
        run(8'hE1, 8'd9, 8'd9, 8'h44, "R9");
        run(8'hE2, 8'd200, 8'd5, 8'h44, "R9");
        run(8'h22, 8'd4, 8'd3, 8'h44, "R9");
        run(8'hE3, 8'd7, 8'd7, 8'h91, "R9");
        run(8'hE4, 8'd128, 8'd127, 8'h91, "R9");
        run(8'hE5, 8'd0, 8'd1, 8'h91, "R9");
        // undefined codes (R10)
        run(8'hC8, 8'd1, 8'd2, 8'd3, "R10");
        run(8'hC9, 8'd1, 8'd2, 8'd3, "R10");
        run(8'h0E, 8'd1, 8'd2, 8'd3, "R10");
        run(8'hE6, 8'd1, 8'd1, 8'd3, "R10");
        run(8'hFF, 8'd1, 8'd2, 8'd3, "R10");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (i % 2 == 0) op[5:0] = (op[0]) ? 6'(32 + ($urandom % 6)) : 6'($urandom % 11);
            if (i % 16 == 0)
                for (int k = 0; k < 8; k++) regs[k] = 8'($urandom);
            run(op, 8'($urandom), 8'($urandom), 8'($urandom), tag_of(op[5:0]));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule